// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. During a write transfer it gathers up to one page (16 bytes by default) of data into a slot buffer. After that it copies the buffered bytes into a 1024-by-8 array during one internally timed write window. The protocol engine opens a transfer with a byte address. It then strobes in data bytes one at a time and ends the transfer with either a commit request or an abort.

Each loaded byte goes to the slot the in-page pointer names. After each load, only the low slot bits of the pointer advance. The pointer wraps inside the page, so a long transfer overwrites the slots it filled first. A commit copies only the slots that were loaded, one slot per clock in ascending slot order. The busy flag stays high for a fixed, parameterised number of clocks. The protocol engine uses this flag for acknowledge polling and ignores the bus while it is high.

The block also presents the post-write address for the engine's address counter. A separate registered read port lets later reads see the array. Bytes that have never been written read as 0xFF after reset, which is the erased state.

Top module: `eeprom_page_writer`

## Requirements
- R1: `start_req` latches the page number from `start_addr[9:4]` and the slot pointer from `start_addr[3:0]`, clears every slot-valid bit and opens the transfer. Each accepted `load_req` stores `load_data` into the slot at the pointer and then increments only the 4-bit pointer. The page bits of `next_addr` do not change.
- R2: After slot 15 the pointer wraps to slot 0 of the same page. A later byte loaded into an already filled slot replaces the earlier byte.
- R3: `next_addr` is {page, pointer}: the address one past the last loaded byte, wrapped inside the page. It reads 0 after reset.
- R4: A commit writes each loaded slot exactly once, in ascending slot order. The write for slot s appears on `mem_we`/`mem_waddr`/`mem_wdata` in busy cycle s+2, counting the first busy cycle as 1, at address {page, s}. Slots that were not loaded are never written.
- R5: When `commit_req` is accepted with at least one loaded slot, `busy` rises in the next cycle and stays high for exactly WRITE_CYCLES clocks. WRITE_CYCLES must exceed the page size.
- R6: While `busy` is high, `start_req`, `load_req`, `commit_req` and `abort_req` have no effect. In particular `next_addr` and the committed data do not change.
- R7: `rd_data` returns, one clock after `rd_addr` is presented, the array byte as it was before any write in that same clock. Bytes never written since reset read as 0xFF.
- R8: An abort, or a commit with no loaded slot, discards the buffer and closes the transfer without raising `busy`. All valid bits are cleared when a commit window ends, so a following empty commit does not raise `busy`.
- R9: When several requests are presented in one idle cycle, only the highest-priority one acts. The order, highest first, is abort, commit, start, load. A load is accepted only while a transfer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Open a transfer at `start_addr` |
| start_addr | input | 10 | Starting byte address (page and slot) |
| load_req | input | 1 | Load one data byte |
| load_data | input | 8 | Data byte for `load_req` |
| commit_req | input | 1 | End the transfer and start the timed write |
| abort_req | input | 1 | Discard the buffer and close the transfer |
| rd_addr | input | 10 | Array read address |
| busy | output | 1 | Timed write window in progress |
| next_addr | output | 10 | Address after the last loaded byte, within the page |
| mem_we | output | 1 | Array write strobe (registered) |
| mem_waddr | output | 10 | Array write address (registered) |
| mem_wdata | output | 8 | Array write data (registered) |
| rd_data | output | 8 | Registered array read data |

## Verification
Suppose the slot pointer or page latch were corrupted. `next_addr` would show the error in the cycle after the offending load, because it is read straight from those registers. A wrong valid bit would not show until the commit: a write pulse would appear or go missing on the write port in a specific busy cycle. That cycle would be at most sixteen cycles into the window. Through the read port, the same fault would appear as wrong data one clock after the affected address is read. A miscounted timer would show as a busy window of the wrong length. It would also show as a first busy cycle that comes one clock early or late against the commit request. The bench therefore compares busy, `next_addr`, every write-port field and `rd_data` against a behavioural model on every clock.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_ABORT  = 3'd1,
    CMD_COMMIT = 3'd2,
    CMD_START  = 3'd3,
    CMD_LOAD   = 3'd4
  } pwb_cmd_e;

  // Fixed priority: abort > commit > start > load
  function automatic pwb_cmd_e pick_cmd(input logic abort_i, input logic commit_i,
                                        input logic start_i, input logic load_i);
    if (abort_i)       return CMD_ABORT;
    else if (commit_i) return CMD_COMMIT;
    else if (start_i)  return CMD_START;
    else if (load_i)   return CMD_LOAD;
    else               return CMD_NONE;
  endfunction

endpackage

// File: rtl/pwb_slot_buffer.sv
module pwb_slot_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pwb_cmd_e                 cmd,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic [DATA_W-1:0]        load_data,
  input  logic                     clear_all,
  input  logic [SLOT_W-1:0]        look_slot,
  output logic                     look_valid,
  output logic [DATA_W-1:0]        look_data,
  output logic                     any_valid,
  output logic                     xfer_open,
  output logic [ADDR_W-SLOT_W-1:0] page,
  output logic [SLOT_W-1:0]        ptr
);

  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [SLOTS-1:0]  vld;
  logic [DATA_W-1:0] dat [SLOTS];
  logic              take_load;

  assign take_load = (cmd == CMD_LOAD) && xfer_open;

  // page latch, pointer and transfer state
  always_ff @(posedge clk) begin
    if (rst) begin
      page      <= '0;
      ptr       <= '0;
      xfer_open <= 1'b0;
    end else begin
      case (cmd)
        CMD_START: begin
          page      <= start_addr[ADDR_W-1:SLOT_W];
          ptr       <= start_addr[SLOT_W-1:0];
          xfer_open <= 1'b1;
        end
        CMD_ABORT, CMD_COMMIT: xfer_open <= 1'b0;
        CMD_LOAD: if (xfer_open) ptr <= ptr + 1'b1;
        default: ;
      endcase
    end
  end

  // one register slice per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = take_load && (ptr == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
        dat[g] <= '0;
      end else begin
        if (clear_all || cmd == CMD_START || cmd == CMD_ABORT)
          vld[g] <= 1'b0;
        else if (hit)
          vld[g] <= 1'b1;
        if (hit)
          dat[g] <= load_data;
      end
    end
  end

  assign any_valid  = |vld;
  assign look_valid = vld[look_slot];
  assign look_data  = dat[look_slot];

  logic unused_w;
  assign unused_w = (PAGE_W == 0);

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int SLOT_W       = 4,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              busy,
  output logic              done,
  output logic              scan_on,
  output logic [SLOT_W-1:0] scan_slot
);

  localparam int SLOTS = 1 << SLOT_W;
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  logic [CNT_W-1:0]  remain;
  logic [SLOT_W:0]   scan;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      scan   <= '0;
    end else if (busy) begin
      if (remain == '0)
        busy <= 1'b0;
      else
        remain <= remain - 1'b1;
      if (scan != (SLOT_W+1)'(SLOTS))
        scan <= scan + 1'b1;
    end else if (go) begin
      busy   <= 1'b1;
      remain <= CNT_W'(WRITE_CYCLES - 1);
      scan   <= '0;
    end
  end

  assign done      = busy && (remain == '0);
  assign scan_on   = busy && (scan != (SLOT_W+1)'(SLOTS));
  assign scan_slot = scan[SLOT_W-1:0];

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  // erased-state tracking in flops
  always_ff @(posedge clk) begin
    if (rst)
      written <= '0;
    else if (we)
      written[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '1;
    else
      rdata <= written[raddr] ? mem[raddr] : '1;
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int SLOT_W       = 4,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_data,
  input  logic              commit_req,
  input  logic              abort_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [ADDR_W-1:0] next_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAGE_W = ADDR_W - SLOT_W;

  pwb_cmd_e            cmd;
  logic                any_valid;
  logic                xfer_open;
  logic [PAGE_W-1:0]   page;
  logic [SLOT_W-1:0]   ptr;
  logic                seq_done;
  logic                scan_on;
  logic [SLOT_W-1:0]   scan_slot;
  logic                look_valid;
  logic [DATA_W-1:0]   look_data;
  logic                go;

  // requests are dropped during the write window
  assign cmd = busy ? CMD_NONE : pick_cmd(abort_req, commit_req, start_req, load_req);
  assign go  = (cmd == CMD_COMMIT) && any_valid;

  pwb_slot_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .start_addr(start_addr),
    .load_data (load_data),
    .clear_all (seq_done),
    .look_slot (scan_slot),
    .look_valid(look_valid),
    .look_data (look_data),
    .any_valid (any_valid),
    .xfer_open (xfer_open),
    .page      (page),
    .ptr       (ptr)
  );

  pwb_commit_seq #(
    .SLOT_W(SLOT_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .busy     (busy),
    .done     (seq_done),
    .scan_on  (scan_on),
    .scan_slot(scan_slot)
  );

  // registered array write port
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= scan_on && look_valid;
      mem_waddr <= {page, scan_slot};
      mem_wdata <= look_data;
    end
  end

  assign next_addr = {page, ptr};

  pwb_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk  (clk),
    .rst  (rst),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W       = 10,
  parameter int SLOT_W       = 4,
  parameter int WRITE_CYCLES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              start_req,
  input logic              load_req,
  input logic              commit_req,
  input logic              abort_req,
  input logic              any_valid,
  input logic              xfer_open,
  input logic [ADDR_W-1:0] next_addr,
  input logic              mem_we
);

  int unsigned run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else     run <= busy ? run + 1 : 0;
  end

  a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (!busy && commit_req && !abort_req && any_valid) |=> busy);

  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    (!busy && run != 0) |-> run == WRITE_CYCLES);

  a_r5_busy_max: assert property (@(posedge clk) disable iff (rst)
    busy |-> run < WRITE_CYCLES);

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(next_addr));

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && abort_req) |=> !busy);

  a_r8_empty_commit: assert property (@(posedge clk) disable iff (rst)
    (!busy && commit_req && !any_valid) |=> !busy);

  a_r4_write_in_window: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(busy));

  a_r1_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (!busy && load_req && xfer_open && !start_req && !commit_req && !abort_req)
      |=> next_addr[ADDR_W-1:SLOT_W] == $past(next_addr[ADDR_W-1:SLOT_W]));

endmodule

bind eeprom_page_writer pwb_checker #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .start_req (start_req),
  .load_req  (load_req),
  .commit_req(commit_req),
  .abort_req (abort_req),
  .any_valid (any_valid),
  .xfer_open (xfer_open),
  .next_addr (next_addr),
  .mem_we    (mem_we)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;

  localparam int W = 24;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 0, load_req = 0, commit_req = 0, abort_req = 0;
  logic [9:0] start_addr = '0, rd_addr = '0;
  logic [7:0] load_data = '0;
  logic       busy, mem_we;
  logic [9:0] next_addr, mem_waddr;
  logic [7:0] mem_wdata, rd_data;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.WRITE_CYCLES(W)) u_eeprom_page_writer (
    .clk(clk), .rst(rst), .start_req(start_req), .start_addr(start_addr),
    .load_req(load_req), .load_data(load_data), .commit_req(commit_req),
    .abort_req(abort_req), .rd_addr(rd_addr), .busy(busy), .next_addr(next_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .rd_data(rd_data));

  // behavioural reference model
  int m_mem [1024];
  int m_val [P];
  int m_dat [P];
  int m_busy, m_cnt, m_scan, m_open, m_page, m_ptr, m_we, m_wa, m_wd, m_rd;

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) m_mem[i] = 255;
    for (int i = 0; i < P; i++) begin m_val[i] = 0; m_dat[i] = 0; end
    m_busy = 0; m_cnt = 0; m_scan = 0; m_open = 0; m_page = 0; m_ptr = 0;
    m_we = 0; m_wa = 0; m_wd = 0; m_rd = 255;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      int n_we, n_wa, n_wd, any;
      m_rd = m_mem[rd_addr];
      if (m_we != 0) m_mem[m_wa] = m_wd;
      n_we = (m_busy != 0 && m_scan < P && m_val[m_scan % P] != 0) ? 1 : 0;
      n_wa = m_page * P + (m_scan % P);
      n_wd = m_dat[m_scan % P];
      any = 0;
      for (int i = 0; i < P; i++) if (m_val[i] != 0) any = 1;
      if (m_busy != 0) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          for (int i = 0; i < P; i++) m_val[i] = 0;
        end else m_cnt--;
        if (m_scan < P) m_scan++;
      end else if (abort_req) begin
        for (int i = 0; i < P; i++) m_val[i] = 0;
        m_open = 0;
      end else if (commit_req) begin
        m_open = 0;
        if (any != 0) begin m_busy = 1; m_cnt = W - 1; m_scan = 0; end
      end else if (start_req) begin
        m_page = start_addr / P; m_ptr = start_addr % P; m_open = 1;
        for (int i = 0; i < P; i++) m_val[i] = 0;
      end else if (load_req && m_open != 0) begin
        m_val[m_ptr] = 1; m_dat[m_ptr] = load_data; m_ptr = (m_ptr + 1) % P;
      end
      m_we = n_we; m_wa = n_wa; m_wd = n_wd;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R5 busy", busy, m_busy);
      check("R3 next_addr", next_addr, m_page * P + m_ptr);
      check("R4 mem_we", mem_we, m_we);
      if (m_we != 0) begin
        check("R4 mem_waddr", mem_waddr, m_wa);
        check("R4 mem_wdata", mem_wdata, m_wd);
      end
      check("R7 rd_data", rd_data, m_rd);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic drive(input bit st, input int a, input bit ld, input int d,
                       input bit cm, input bit ab);
    @(negedge clk);
    start_req = st; start_addr = 10'(a); load_req = ld; load_data = 8'(d);
    commit_req = cm; abort_req = ab;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  // waits out a window and checks its length
  task automatic wait_window(input string tag, input int exp_len);
    int len = 0;
    drive(0, 0, 0, 0, 0, 0);
    while (busy && len < 1000) begin len++; @(negedge clk); end
    check(tag, len, exp_len);
    idle(2);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    @(negedge clk);
    start_req = 0; load_req = 0; commit_req = 0; abort_req = 0; rd_addr = 10'(a);
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 0;
    // reset state
    check("R5 reset busy", busy, 0);
    check("R3 reset next_addr", next_addr, 0);
    rd_chk("R7 erased 0x3FF", 10'h3FF, 8'hFF);
    rd_chk("R7 erased 0x123", 10'h123, 8'hFF);

    // R1/R4/R5: short write from mid-page
    drive(1, 10'h123, 0, 0, 0, 0);
    drive(0, 0, 1, 8'hA1, 0, 0);
    drive(0, 0, 1, 8'hA2, 0, 0);
    drive(0, 0, 1, 8'hA3, 0, 0);
    idle(1);
    check("R1 next_addr after loads", next_addr, 10'h126);
    drive(0, 0, 0, 0, 1, 0);
    wait_window("R5 window length", W);
    rd_chk("R1 byte 0x123", 10'h123, 8'hA1);
    rd_chk("R1 byte 0x125", 10'h125, 8'hA3);
    rd_chk("R4 untouched 0x126", 10'h126, 8'hFF);
    rd_chk("R4 untouched 0x122", 10'h122, 8'hFF);

    // R2: 20 bytes from slot 14 wrap and overwrite
    drive(1, 10'h3FE, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) drive(0, 0, 1, 8'h40 + i, 0, 0);
    idle(1);
    check("R2 next_addr wrapped", next_addr, 10'h3F2);
    drive(0, 0, 0, 0, 1, 0);
    // R6: requests during the window are ignored
    drive(1, 10'h000, 0, 0, 0, 0);
    drive(0, 0, 1, 8'hEE, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1, 0);
    check("R6 next_addr held", next_addr, 10'h3F2);
    wait_window("R6 window not restarted", W - 4);
    check("R6 next_addr after window", next_addr, 10'h3F2);
    rd_chk("R2 overwritten slot0", 10'h3F0, 8'h52);
    rd_chk("R2 overwritten slot1", 10'h3F1, 8'h53);
    rd_chk("R2 slot2", 10'h3F2, 8'h44);
    rd_chk("R2 slot14", 10'h3FE, 8'h50);
    rd_chk("R6 no stray write 0x000", 10'h000, 8'hFF);

    // R8: abort discards, then empty commit
    drive(1, 10'h200, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h11, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1, 0);
    idle(2);
    check("R8 abort then commit no busy", busy, 0);
    rd_chk("R8 aborted byte", 10'h200, 8'hFF);
    drive(1, 10'h050, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    idle(2);
    check("R8 empty commit no busy", busy, 0);

    // R9: priority cases
    drive(1, 10'h080, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h77, 0, 0);
    drive(0, 0, 0, 0, 1, 1);
    idle(2);
    check("R9 abort beats commit", busy, 0);
    rd_chk("R9 abort beats commit data", 10'h080, 8'hFF);
    drive(1, 10'h090, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h01, 0, 0);
    drive(0, 0, 1, 8'h02, 1, 0);
    idle(1);
    check("R9 commit beats load busy", busy, 1);
    check("R9 commit beats load addr", next_addr, 10'h091);
    wait_window("R5 second window", W - 1);
    rd_chk("R9 loaded byte", 10'h090, 8'h01);
    rd_chk("R9 dropped load", 10'h091, 8'hFF);
    drive(1, 10'h0A5, 1, 8'h33, 0, 0);
    idle(1);
    check("R9 start beats load", next_addr, 10'h0A5);
    drive(0, 0, 0, 0, 1, 0);
    idle(2);
    check("R8 R9 commit after start-only", busy, 0);
    // load without an open transfer is ignored
    drive(0, 0, 1, 8'h99, 0, 0);
    idle(1);
    check("R9 load while closed", next_addr, 10'h0A5);

    idle(3);
    finish_run();
  end

endmodule